// File: doc/BRIEF.md
# SD Card Command Path Controller

This block is the command half of an SD/MMC host. Software loads a 32-bit argument and then writes a command word. When the enable bit of that word is set, the block sends a 48-bit command frame on the command line, one bit per card clock enable. It then receives a short or long response, or none, as the response code selects, and checks the response's 7-bit CRC. After a response it watches D0 for card busy.

Results appear in a register of sticky status flags, which are cleared by write-one-to-clear. The response payload is held in four 32-bit words. Two status bits are live rather than sticky: one shows that a command is in progress, the other that the card holds D0 low. The block does no data transfer and does not generate the card clock. It only acts on cycles where `ck_en` is high.

Top module: `sd_cmd_path`

## Requirements
- R1: A started command drives a 48-bit frame, most significant bit first, one bit per `ck_en` cycle, with `cmd_oe` high. The frame is start bit 0, bit 1, the 6-bit index, the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, zero seed) of the first 40 bits, and end bit 1. On the `ck_en` after the end bit, `cmd_oe` drops and `cmd_out` rests high.
- R2: The command word (index 1) holds the index in bits 5:0, a data-transfer marker in bit 6, a stop marker in bit 7, the response code in bits 9:8 and the enable in bit 12. A read returns the written value masked to those bits. A write with bit 12 set starts a command.
- R3: With response code 00, status bit 7 ("sent") sets on the `ck_en` that ends the frame, and no response is awaited.
- R4: Response codes 01 and 11 check the received CRC7. A match sets status bit 6 ("response received"); a mismatch sets status bit 0 and not bit 6. Code 10 sets bit 6 whatever the CRC.
- R5: After the frame, the block samples `cmd_in` on up to 64 `ck_en` cycles. A start bit (0) on any of them begins reception. If all 64 samples are high, status bit 2 ("command timeout") sets.
- R6: A short response (codes 01, 10) stores its 32 payload bits in response word 0 (index 2) and leaves words 1 to 3 unchanged. A long response (code 11) fills words 0 to 3 (indices 2 to 5) with its 127 bits after the 8 header bits, followed by a 0.
- R7: After a good response, `dat0_in` is sampled on the next `ck_en`. If it is low, status bit 20 ("busy") goes high. On the k-th following `ck_en`, a high D0 sets bit 21 ("busy end") and clears bit 20. If D0 is still low and k equals the data timer (index 6), bit 3 ("data timeout") sets instead.
- R8: A command-word write with bit 12 clear returns the block to idle at once. `cmd_oe` goes low and no flag sets.
- R9: Status (index 7) bits 11:0 and 28:21 are sticky. Writing 1 to the same bit at index 8 clears them. Bits 13 and 20 are live and are not affected by that write.
- R10: Status bit 13 is high from the starting write until the command finishes, ends in an error, or is aborted.
- R11: After reset, status and response words read 0, `cmd_oe` is 0 and `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ck_en | input | 1 | Card clock enable, one system cycle per card clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read index |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_addr` |
| cmd_in | input | 1 | Command line input from card |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| dat0_in | input | 1 | D0 input, used for busy detection |

## Verification
The assertions assume a well-behaved environment. `ck_en` is a single-cycle pulse. Register writes never coincide with the `ck_en` cycle that would complete a command. The card drives `cmd_in` only while `cmd_oe` is low. The stimulus holds `ck_en` high for one system cycle in every four, and it makes every register access between card clock pulses. The card model drives `cmd_in` high during the whole frame and D0 high except inside the busy windows it is testing.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_WAIT, S_RX, S_BCHK, S_BUSY
  } sdc_state_t;

  localparam int ST_CCRC  = 0;
  localparam int ST_CTMO  = 2;
  localparam int ST_DTMO  = 3;
  localparam int ST_REND  = 6;
  localparam int ST_SENT  = 7;
  localparam int ST_ACT   = 13;
  localparam int ST_BUSY  = 20;
  localparam int ST_BEND  = 21;

  localparam logic [31:0] CLR_MASK = 32'h1FE0_0FFF;
  localparam logic [31:0] CMD_MASK = 32'h0000_13FF;

  localparam logic [3:0] A_ARG  = 4'd0;
  localparam logic [3:0] A_CMD  = 4'd1;
  localparam logic [3:0] A_RSP0 = 4'd2;
  localparam logic [3:0] A_RSP1 = 4'd3;
  localparam logic [3:0] A_RSP2 = 4'd4;
  localparam logic [3:0] A_RSP3 = 4'd5;
  localparam logic [3:0] A_DTIM = 4'd6;
  localparam logic [3:0] A_STAT = 4'd7;
  localparam logic [3:0] A_CLR  = 4'd8;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);
  logic fb;
  assign fb = din ^ crc[6];

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  end
endmodule

// File: rtl/sdc_engine.sv
module sdc_engine #(
  parameter int DT_W  = 32,
  parameter int TO_CK = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ck_en,
  input  logic            start,
  input  logic            abort,
  input  logic [5:0]      idx,
  input  logic [31:0]     arg,
  input  logic [1:0]      rtype,
  input  logic [DT_W-1:0] dtimer,
  input  logic            cmd_in,
  input  logic            dat0_in,
  output logic            cmd_out,
  output logic            cmd_oe,
  output logic            active,
  output logic            busy,
  output logic            ev_sent,
  output logic            ev_rend,
  output logic            ev_ccrc,
  output logic            ev_ctmo,
  output logic            ev_dtmo,
  output logic            ev_bend,
  output logic            resp_vld,
  output logic            resp_long,
  output logic [127:0]    resp_bits
);
  import sdc_pkg::*;

  localparam int WC_W = $clog2(TO_CK);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(TO_CK - 1);

  sdc_state_t      state_q;
  logic [39:0]     tx_sr;
  logic [126:0]    rx_sr;
  logic [7:0]      cnt_q;
  logic [WC_W-1:0] wcnt_q;
  logic [DT_W-1:0] bcnt_q;
  logic [1:0]      rtype_q;
  logic [6:0]      crc_q;
  logic            crc_clr, crc_en, crc_din;
  logic            long_r, chk_crc;
  logic [7:0]      rx_lo, rx_hi, rx_last;

  assign long_r  = (rtype_q == 2'b11);
  assign chk_crc = rtype_q[0];
  assign rx_lo   = long_r ? 8'd8   : 8'd1;
  assign rx_hi   = long_r ? 8'd127 : 8'd39;
  assign rx_last = long_r ? 8'd135 : 8'd47;
  assign active  = (state_q != S_IDLE);

  assign crc_clr = start || (ck_en && state_q == S_WAIT && !cmd_in);
  assign crc_en  = ck_en && !start && !abort &&
                   ((state_q == S_TX && cnt_q < 8'd40) ||
                    (state_q == S_RX && cnt_q >= rx_lo && cnt_q <= rx_hi));
  assign crc_din = (state_q == S_TX) ? tx_sr[39] : cmd_in;

  sdc_crc7 u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      tx_sr     <= '0;
      rx_sr     <= '0;
      cnt_q     <= '0;
      wcnt_q    <= '0;
      bcnt_q    <= '0;
      rtype_q   <= '0;
      cmd_out   <= 1'b1;
      cmd_oe    <= 1'b0;
      busy      <= 1'b0;
      ev_sent   <= 1'b0;
      ev_rend   <= 1'b0;
      ev_ccrc   <= 1'b0;
      ev_ctmo   <= 1'b0;
      ev_dtmo   <= 1'b0;
      ev_bend   <= 1'b0;
      resp_vld  <= 1'b0;
      resp_long <= 1'b0;
      resp_bits <= '0;
    end else begin
      ev_sent  <= 1'b0;
      ev_rend  <= 1'b0;
      ev_ccrc  <= 1'b0;
      ev_ctmo  <= 1'b0;
      ev_dtmo  <= 1'b0;
      ev_bend  <= 1'b0;
      resp_vld <= 1'b0;
      if (abort) begin
        state_q <= S_IDLE;
        cmd_oe  <= 1'b0;
        cmd_out <= 1'b1;
        busy    <= 1'b0;
      end else if (start) begin
        state_q <= S_TX;
        cnt_q   <= '0;
        tx_sr   <= {2'b01, idx, arg};
        rtype_q <= rtype;
        cmd_oe  <= 1'b0;
        cmd_out <= 1'b1;
        busy    <= 1'b0;
      end else if (ck_en) begin
        case (state_q)
          S_TX: begin
            if (cnt_q == 8'd48) begin
              cmd_oe  <= 1'b0;
              cmd_out <= 1'b1;
              if (rtype_q == 2'b00) begin
                ev_sent <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                wcnt_q  <= '0;
                state_q <= S_WAIT;
              end
            end else begin
              cmd_oe <= 1'b1;
              cnt_q  <= cnt_q + 8'd1;
              if (cnt_q < 8'd40) begin
                cmd_out <= tx_sr[39];
                tx_sr   <= {tx_sr[38:0], 1'b0};
              end else if (cnt_q == 8'd40) begin
                cmd_out <= crc_q[6];
                tx_sr   <= {crc_q[5:0], 34'b0};
              end else if (cnt_q < 8'd47) begin
                cmd_out <= tx_sr[39];
                tx_sr   <= {tx_sr[38:0], 1'b0};
              end else begin
                cmd_out <= 1'b1;
              end
            end
          end
          S_WAIT: begin
            if (!cmd_in) begin
              rx_sr   <= '0;
              cnt_q   <= 8'd1;
              state_q <= S_RX;
            end else if (wcnt_q == WC_LAST) begin
              ev_ctmo <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
          S_RX: begin
            rx_sr <= {rx_sr[125:0], cmd_in};
            cnt_q <= cnt_q + 8'd1;
            if (cnt_q == rx_last) begin
              if (chk_crc && crc_q != rx_sr[6:0]) begin
                ev_ccrc <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                ev_rend   <= 1'b1;
                resp_vld  <= 1'b1;
                resp_long <= long_r;
                resp_bits <= long_r ? {rx_sr, 1'b0} : {96'b0, rx_sr[38:7]};
                state_q   <= S_BCHK;
              end
            end
          end
          S_BCHK: begin
            if (dat0_in) begin
              state_q <= S_IDLE;
            end else begin
              busy    <= 1'b1;
              bcnt_q  <= '0;
              state_q <= S_BUSY;
            end
          end
          S_BUSY: begin
            if (dat0_in) begin
              busy    <= 1'b0;
              ev_bend <= 1'b1;
              state_q <= S_IDLE;
            end else if (({1'b0, bcnt_q} + (DT_W+1)'(1)) >= {1'b0, dtimer}) begin
              busy    <= 1'b0;
              ev_dtmo <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_OE_IN_TX: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> state_q == S_TX); // R1
  AST_SENT_NO_RESP: assert property (@(posedge clk) disable iff (rst)
    ev_sent |-> rtype_q == 2'b00); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_sent, ev_rend, ev_ccrc, ev_ctmo})); // R4
  AST_BUSY_AFTER_RESP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(state_q) == S_BCHK); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> !active && !cmd_oe); // R8
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path #(
  parameter int DT_W  = 32,
  parameter int TO_CK = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ck_en,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        cmd_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        dat0_in
);
  import sdc_pkg::*;

  logic [31:0]     arg_q, cmd_q, sta_q;
  logic [31:0]     rsp_q [4];
  logic [DT_W-1:0] dtim_q;
  logic            start, abort, active, busy;
  logic            ev_sent, ev_rend, ev_ccrc, ev_ctmo, ev_dtmo, ev_bend;
  logic            resp_vld, resp_long;
  logic [127:0]    resp_bits;
  logic [31:0]     set_vec, clr_vec, sta_view;

  assign start = wr_en && wr_addr == A_CMD &&  wr_data[12];
  assign abort = wr_en && wr_addr == A_CMD && !wr_data[12];

  sdc_engine #(.DT_W(DT_W), .TO_CK(TO_CK)) u_eng (
    .clk(clk), .rst(rst), .ck_en(ck_en), .start(start), .abort(abort),
    .idx(wr_data[5:0]), .arg(arg_q), .rtype(wr_data[9:8]), .dtimer(dtim_q),
    .cmd_in(cmd_in), .dat0_in(dat0_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .active(active), .busy(busy), .ev_sent(ev_sent), .ev_rend(ev_rend),
    .ev_ccrc(ev_ccrc), .ev_ctmo(ev_ctmo), .ev_dtmo(ev_dtmo), .ev_bend(ev_bend),
    .resp_vld(resp_vld), .resp_long(resp_long), .resp_bits(resp_bits)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_CCRC] = ev_ccrc;
    set_vec[ST_CTMO] = ev_ctmo;
    set_vec[ST_DTMO] = ev_dtmo;
    set_vec[ST_REND] = ev_rend;
    set_vec[ST_SENT] = ev_sent;
    set_vec[ST_BEND] = ev_bend;
    clr_vec  = (wr_en && wr_addr == A_CLR) ? (wr_data & CLR_MASK) : 32'b0;
    sta_view = sta_q;
    sta_view[ST_ACT]  = active;
    sta_view[ST_BUSY] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q   <= '0;
      cmd_q   <= '0;
      dtim_q  <= '0;
      sta_q   <= '0;
      rd_data <= '0;
      for (int i = 0; i < 4; i++) rsp_q[i] <= '0;
    end else begin
      sta_q <= (sta_q & ~clr_vec) | set_vec;
      if (wr_en && wr_addr == A_ARG)  arg_q  <= wr_data;
      if (wr_en && wr_addr == A_CMD)  cmd_q  <= wr_data & CMD_MASK;
      if (wr_en && wr_addr == A_DTIM) dtim_q <= wr_data[DT_W-1:0];
      if (resp_vld) begin
        rsp_q[0] <= resp_long ? resp_bits[127:96] : resp_bits[31:0];
        if (resp_long) begin
          rsp_q[1] <= resp_bits[95:64];
          rsp_q[2] <= resp_bits[63:32];
          rsp_q[3] <= resp_bits[31:0];
        end
      end
      case (rd_addr)
        A_ARG:   rd_data <= arg_q;
        A_CMD:   rd_data <= cmd_q;
        A_RSP0:  rd_data <= rsp_q[0];
        A_RSP1:  rd_data <= rsp_q[1];
        A_RSP2:  rd_data <= rsp_q[2];
        A_RSP3:  rd_data <= rsp_q[3];
        A_DTIM:  rd_data <= 32'(dtim_q);
        A_STAT:  rd_data <= sta_view;
        default: rd_data <= '0;
      endcase
    end
  end

  AST_W1C_REND: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CLR && wr_data[ST_REND] && !ev_rend) |=> !sta_q[ST_REND]); // R9
  AST_STICKY_SENT: assert property (@(posedge clk) disable iff (rst)
    (sta_q[ST_SENT] && !(wr_en && wr_addr == A_CLR)) |=> sta_q[ST_SENT]); // R9
  AST_BEND_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(sta_q[ST_BEND]) |-> $past(busy, 2)); // R7
endmodule

// File: tb/tb_sd_cmd_path.sv
module tb_sd_cmd_path;
  logic        clk = 0, rst = 1, ck_en = 0, wr_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        cmd_in = 1, cmd_out, cmd_oe, dat0_in = 1;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  sd_cmd_path dut (
    .clk(clk), .rst(rst), .ck_en(ck_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .dat0_in(dat0_in)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] crc_ref(input logic [127:0] m, input int n);
    logic [134:0] v;
    v = {7'b0, m} << 7;
    for (int i = n + 6; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic c, input logic d);
    @(negedge clk); cmd_in = c; dat0_in = d; ck_en = 1;
    @(negedge clk); ck_en = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                       input string req);
    logic [47:0] got, exp;
    logic        oe_all;
    logic [39:0] hdr;
    hdr = {2'b01, idx, arg};
    exp = {hdr, crc_ref({88'b0, hdr}, 40), 1'b1};
    oe_all = 1;
    wr(4'd0, arg);
    wr(4'd1, 32'h1000 | (32'(rt) << 8) | 32'(idx));
    for (int k = 0; k < 48; k++) begin
      tick(1, 1);
      oe_all &= cmd_oe;
      got[47-k] = cmd_out;
    end
    check({req, " R1 frame"}, 128'(got), 128'(exp));
    check({req, " R1 oe during frame"}, 128'(oe_all), 128'(1));
    tick(1, 1);
    check({req, " R1 line released"}, 128'({cmd_oe, cmd_out}), 128'(2'b01));
  endtask

  task automatic respond(input int dly, input bit lng, input logic [119:0] pl,
                         input logic [5:0] ridx, input bit bad);
    logic [135:0] fr;
    int           nb;
    if (lng) begin
      fr = {2'b00, 6'h3F, pl, crc_ref({8'b0, pl}, 120) ^ {6'b0, bad}, 1'b1};
      nb = 136;
    end else begin
      fr = {88'b0, 2'b00, ridx, pl[31:0],
            crc_ref({88'b0, 2'b00, ridx, pl[31:0]}, 40) ^ {6'b0, bad}, 1'b1};
      nb = 48;
    end
    for (int k = 0; k < dly; k++) tick(1, 1);
    for (int k = nb - 1; k >= 0; k--) tick(fr[k], 1);
  endtask

  logic [31:0] r;
  logic [119:0] lp;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset state
    rd(4'd7, r); check("R11 status", 128'(r), 0);
    rd(4'd2, r); check("R11 resp0", 128'(r), 0);
    check("R11 line", 128'({cmd_oe, cmd_out}), 128'(2'b01));

    // R2 readback, abort-only write
    wr(4'd1, 32'hFFFF_EFFF);
    rd(4'd1, r); check("R2 cmd readback", 128'(r), 128'(32'h0000_03FF));

    // R10 active after start, R3 sent
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h1000);
    rd(4'd7, r); check("R10 active at start", 128'(r[13]), 1);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd7, r); check("R9 live bit not cleared", 128'(r[13]), 1);
    wr(4'd1, 32'h0);
    issue(6'd0, 32'h0, 2'b00, "cmd0");
    rd(4'd7, r); check("R3 sent only", 128'(r), 128'(32'h80));
    wr(4'd8, 32'h80);
    rd(4'd7, r); check("R9 cleared", 128'(r), 0);

    // R1 sweep over all indices
    for (int i = 0; i < 64; i++) begin
      issue(6'(i), 32'(i) * 32'h0101_0101 ^ 32'hA5C3_1E77, 2'b00, "sweep");
      rd(4'd7, r); check("R3 sweep sent", 128'(r[7]), 1);
      wr(4'd8, 32'hFFFF_FFFF);
    end

    // R4/R6 short good, R5 start on 64th sample
    issue(6'd17, 32'h1234_5678, 2'b01, "cmd17");
    respond(63, 0, 120'hDEAD_BEEF, 6'd17, 0);
    tick(1, 1);
    rd(4'd7, r); check("R4 R5 good short", 128'(r), 128'(32'h40));
    rd(4'd2, r); check("R6 short resp0", 128'(r), 128'(32'hDEAD_BEEF));
    wr(4'd8, 32'hFFFF_FFFF);

    // R4 bad crc with check
    issue(6'd13, 32'h0000_0001, 2'b01, "cmd13");
    respond(3, 0, 120'h0BAD_0001, 6'd13, 1);
    tick(1, 1);
    rd(4'd7, r); check("R4 crc fail", 128'(r), 128'(32'h1));
    wr(4'd8, 32'hFFFF_FFFF);

    // R4 bad crc ignored with code 10
    issue(6'd41, 32'h40FF_8000, 2'b10, "acmd41");
    respond(2, 0, 120'hC0FF_8000, 6'h3F, 1);
    tick(1, 1);
    rd(4'd7, r); check("R4 crc ignored", 128'(r), 128'(32'h40));
    rd(4'd2, r); check("R6 ignored resp0", 128'(r), 128'(32'hC0FF_8000));
    wr(4'd8, 32'hFFFF_FFFF);

    // R6 long response
    lp = {32'h0123_4567, 32'h89AB_CDEF, 32'hF0E1_D2C3, 24'hB4A596};
    issue(6'd2, 32'h0, 2'b11, "cmd2");
    respond(5, 1, lp, 6'd0, 0);
    tick(1, 1);
    rd(4'd7, r); check("R4 long good", 128'(r), 128'(32'h40));
    rd(4'd2, r); check("R6 long w0", 128'(r), 128'(32'h0123_4567));
    rd(4'd3, r); check("R6 long w1", 128'(r), 128'(32'h89AB_CDEF));
    rd(4'd4, r); check("R6 long w2", 128'(r), 128'(32'hF0E1_D2C3));
    rd(4'd5, r); check("R6 long w3", 128'(r),
                       128'({24'hB4A596, crc_ref({8'b0, lp}, 120), 1'b0}));
    wr(4'd8, 32'hFFFF_FFFF);

    // R6 short leaves words 1..3
    issue(6'd7, 32'h0001_0000, 2'b01, "cmd7");
    respond(1, 0, 120'h0000_0700, 6'd7, 0);
    tick(1, 1);
    rd(4'd3, r); check("R6 short keeps w1", 128'(r), 128'(32'h89AB_CDEF));
    rd(4'd2, r); check("R6 short w0", 128'(r), 128'(32'h0000_0700));
    wr(4'd8, 32'hFFFF_FFFF);

    // R5 timeout after 64 high samples
    issue(6'd8, 32'h1AA, 2'b01, "cmd8");
    for (int k = 0; k < 63; k++) tick(1, 1);
    rd(4'd7, r); check("R5 no timeout at 63", 128'({r[2], r[13]}), 128'(2'b01));
    tick(1, 1);
    rd(4'd7, r); check("R5 timeout", 128'(r), 128'(32'h4));
    wr(4'd8, 32'hFFFF_FFFF);

    // R7 busy released on sample equal to data timer
    wr(4'd6, 32'd5);
    issue(6'd12, 32'h0, 2'b01, "cmd12");
    respond(2, 0, 120'h0000_0C00, 6'd12, 0);
    tick(1, 0);
    rd(4'd7, r); check("R7 busy live", 128'({r[20], r[13]}), 128'(2'b11));
    for (int k = 0; k < 4; k++) tick(1, 0);
    tick(1, 1);
    rd(4'd7, r); check("R7 busy end", 128'(r), 128'(32'h0020_0040));
    wr(4'd8, 32'hFFFF_FFFF);

    // R7 busy exceeds data timer
    issue(6'd12, 32'h0, 2'b01, "cmd12b");
    respond(2, 0, 120'h0000_0C00, 6'd12, 0);
    tick(1, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    rd(4'd7, r); check("R7 data timeout", 128'(r), 128'(32'h48));
    wr(4'd8, 32'hFFFF_FFFF);
    dat0_in = 1;

    // R8 abort mid-frame
    wr(4'd0, 32'h55);
    wr(4'd1, 32'h1111);
    for (int k = 0; k < 10; k++) tick(1, 1);
    check("R8 oe before abort", 128'(cmd_oe), 1);
    wr(4'd1, 32'h0011);
    check("R8 oe after abort", 128'({cmd_oe, cmd_out}), 128'(2'b01));
    for (int k = 0; k < 80; k++) tick(1, 1);
    rd(4'd7, r); check("R8 R10 idle no flags", 128'(r), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule